// File: doc/BRIEF.md
# I2C SCL Bit-Timing Divider

This block derives the SCL bit timing for an I2C master from a fast system clock. A 9-bit control word carries two fields: a 3-bit coarse prescaler that divides the system clock into an internal bit-timing clock, and a 6-bit fine divisor that stretches each SCL period in steps of eight internal counts. A separate 8-bit compensation input adds the rounded-up count that covers SCL rise time, fall time and internal delay. This count depends on the channel and the clock setting, so it is computed outside the block. Software keeps the internal clock below 20 MHz by choosing the prescaler.

Each SCL period is split into a low half and a high half. The bus engine gets three single-cycle strobes: one at the start of every period, one at the middle of the low half for changing SDA, and one at the middle of the high half for sampling SDA. It also gets the nominal SCL level. A new control word or compensation value is only adopted at a period boundary, so a bit that is already in progress keeps its length. While the master is disabled the counters stay cleared. Enabling the master starts a fresh low phase.

Top module: `sclgen_divider`

## Requirements
- R1: The prescaler field is ctrl_word[2:0] (value P). One internal tick spans P+1 system clock cycles, so a whole SCL period lasts (P+1)·L system cycles.
- R2: The fine divisor is ctrl_word[8:3] (value D, 0 to 63) and the compensation is edge_comp (value F, 0 to 255). The period length is L = 20 + 8·D + F internal ticks, measured between successive period_stb pulses.
- R3: In each period, scl_level is 0 for the first floor(L/2) ticks and 1 for the remaining ticks.
- R4: sda_drive_stb is high for exactly one system cycle per period. That cycle is the first system cycle of tick floor(floor(L/2)/2), counted from 0 at the period start.
- R5: sda_sample_stb is high for exactly one system cycle per period. That cycle is the first system cycle of tick H + floor((L−H)/2), where H = floor(L/2).
- R6: period_stb is high for exactly one system cycle, the first cycle of each period. At most one of the three strobes is high in any cycle.
- R7: A change of ctrl_word or edge_comp while enabled does not change the length of the period in progress. The new values set the period that follows the next boundary.
- R8: While enable is 0, scl_level is 1 and all three strobes are 0.
- R9: In the first cycle with enable high, period_stb is 1 and scl_level is 0. That period uses the ctrl_word and edge_comp present in the cycle before enable rose.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Master interface enable; low holds the counters cleared |
| ctrl_word | input | 9 | [8:3] fine divisor, [2:0] prescaler |
| edge_comp | input | 8 | Rounded-up edge-delay compensation count |
| scl_level | output | 1 | Nominal SCL level |
| period_stb | output | 1 | First cycle of each SCL period |
| sda_drive_stb | output | 1 | Mid-low strobe for changing SDA |
| sda_sample_stb | output | 1 | Mid-high strobe for sampling SDA |

## Verification
The hardest case to reach from the ports is a control word that changes partway through a period. Seen from outside, that looks the same as a period of the wrong length unless the stimulus lines up with a known period start. The bench first locks onto a period_stb pulse. It then changes the word and compensation several cycles into a 20-tick period and counts cycles to the next pulse. After that it measures the following period, which has a different prescaler and divisor, so that both the old and new settings are confirmed. The bench also disables the master mid-period and re-enables it, which exercises the restart path.

// File: rtl/sclgen_pkg.sv
package sclgen_pkg;
  localparam int CDF_W    = 3;
  localparam int SCGD_W   = 6;
  localparam int COMP_W   = 8;
  localparam int CTRL_W   = CDF_W + SCGD_W;
  localparam int BASE_CNT = 20;
  localparam int STEP_CNT = 8;
  localparam int PER_MAX  = BASE_CNT + STEP_CNT * ((1 << SCGD_W) - 1) + (1 << COMP_W) - 1;
  localparam int PER_W    = $clog2(PER_MAX + 1);

  typedef struct packed {
    logic [SCGD_W-1:0] scgd;
    logic [CDF_W-1:0]  cdf;
    logic [COMP_W-1:0] comp;
  } cfg_t;

  function automatic logic [PER_W-1:0] period_len(cfg_t c);
    return PER_W'(BASE_CNT) + PER_W'(STEP_CNT) * PER_W'(c.scgd) + PER_W'(c.comp);
  endfunction
endpackage

// File: rtl/sclgen_cfg_latch.sv
module sclgen_cfg_latch
  import sclgen_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              boundary,
  input  logic [CTRL_W-1:0] ctrl_word,
  input  logic [COMP_W-1:0] edge_comp,
  output cfg_t              cfg_q
);
  cfg_t cfg_d;
  logic load;

  always_comb begin
    load  = !en || boundary;
    cfg_d = cfg_q;
    if (load) begin
      cfg_d.scgd = ctrl_word[CTRL_W-1:CDF_W];
      cfg_d.cdf  = ctrl_word[CDF_W-1:0];
      cfg_d.comp = edge_comp;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  // R7
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && !$past(boundary)) |-> $stable(cfg_q));
endmodule

// File: rtl/sclgen_prescale.sv
module sclgen_prescale
  import sclgen_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CDF_W-1:0] cdf,
  output logic             tick,
  output logic             first
);
  logic [CDF_W-1:0] pre_q, pre_d;

  always_comb begin
    tick  = en && (pre_q == cdf);
    first = en && (pre_q == '0);
    if (!en)       pre_d = '0;
    else if (tick) pre_d = '0;
    else           pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  // R1
  pre_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre_q <= cdf);
endmodule

// File: rtl/sclgen_period.sv
module sclgen_period
  import sclgen_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  input  logic first,
  input  cfg_t cfg,
  output logic boundary,
  output logic scl_level,
  output logic period_stb,
  output logic drive_stb,
  output logic sample_stb
);
  logic [PER_W-1:0] per_q, per_d;
  logic [PER_W-1:0] len, last, half, mid_lo, mid_hi;

  always_comb begin
    len    = period_len(cfg);
    last   = len - 1'b1;
    half   = len >> 1;
    mid_lo = half >> 1;
    mid_hi = half + ((len - half) >> 1);
    boundary = tick && (per_q == last);
    if (!en)           per_d = '0;
    else if (boundary) per_d = '0;
    else if (tick)     per_d = per_q + 1'b1;
    else               per_d = per_q;
    scl_level  = !en || (per_q >= half);
    period_stb = first && (per_q == '0);
    drive_stb  = first && (per_q == mid_lo);
    sample_stb = first && (per_q == mid_hi);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) per_q <= '0;
    else        per_q <= per_d;
  end

  // R2
  per_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    per_q <= last);
  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({period_stb, drive_stb, sample_stb}));
  // R3
  low_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    period_stb |-> !scl_level);
endmodule

// File: rtl/sclgen_divider.sv
module sclgen_divider
  import sclgen_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [CTRL_W-1:0] ctrl_word,
  input  logic [COMP_W-1:0] edge_comp,
  output logic              scl_level,
  output logic              period_stb,
  output logic              sda_drive_stb,
  output logic              sda_sample_stb
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  cfg_t       cfg_q;
  logic       tick, first, boundary, en_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];
  assign en_int    = enable && rst_int_n;

  sclgen_cfg_latch u_cfg (
    .clk(clk), .rst_n(rst_int_n), .en(en_int), .boundary(boundary),
    .ctrl_word(ctrl_word), .edge_comp(edge_comp), .cfg_q(cfg_q));

  sclgen_prescale u_pre (
    .clk(clk), .rst_n(rst_int_n), .en(en_int), .cdf(cfg_q.cdf),
    .tick(tick), .first(first));

  sclgen_period u_per (
    .clk(clk), .rst_n(rst_int_n), .en(en_int), .tick(tick), .first(first),
    .cfg(cfg_q), .boundary(boundary), .scl_level(scl_level),
    .period_stb(period_stb), .drive_stb(sda_drive_stb), .sample_stb(sda_sample_stb));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !enable |-> (scl_level && !period_stb && !sda_drive_stb && !sda_sample_stb));
  // R9
  restart_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(enable) |-> (period_stb && !scl_level));
endmodule

// File: tb/sclgen_divider_bench.sv
module sclgen_divider_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic [8:0] ctrl_word = '0;
  logic [7:0] edge_comp = '0;
  logic       scl_level, period_stb, sda_drive_stb, sda_sample_stb;
  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  sclgen_divider u_sclgen_divider (
    .clk(clk), .rst_n(rst_n), .enable(enable), .ctrl_word(ctrl_word),
    .edge_comp(edge_comp), .scl_level(scl_level), .period_stb(period_stb),
    .sda_drive_stb(sda_drive_stb), .sda_sample_stb(sda_sample_stb));

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic program_word(int cdf, int scgd, int f);
    @(negedge clk);
    enable = 1'b0;
    ctrl_word = 9'((scgd << 3) | cdf);
    edge_comp = 8'(f);
    @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_start();
    int g = 0;
    while (!period_stb && g < 20000) begin @(negedge clk); g++; end
  endtask

  // assumes current negedge shows period_stb; ends at the next period_stb
  task automatic measure(output int per, output int low, output int drv, output int smp,
                         output int ndrv, output int nsmp);
    int i = 0;
    low = 0; drv = -1; smp = -1; ndrv = 0; nsmp = 0;
    do begin
      if (!scl_level) low++;
      if (sda_drive_stb) begin drv = i; ndrv++; end
      if (sda_sample_stb) begin smp = i; nsmp++; end
      @(negedge clk); i++;
    end while (!period_stb && i < 20000);
    per = i;
  endtask

  task automatic run_timing(string tag, int cdf, int scgd, int f);
    int p, l, d, s, nd, ns, len, h;
    len = 20 + 8 * scgd + f;
    h = len / 2;
    program_word(cdf, scgd, f);
    wait_start();
    measure(p, l, d, s, nd, ns);
    $display("timing case %s: L=%0d", tag, len);
    check("R1/R2 period", p, (cdf + 1) * len);
    check("R3 low time", l, (cdf + 1) * h);
    check("R4 drive offset", d, (cdf + 1) * (h / 2));
    check("R4 drive count", nd, 1);
    check("R5 sample offset", s, (cdf + 1) * (h + (len - h) / 2));
    check("R5 sample count", ns, 1);
  endtask

  task automatic test_reset();
    check("R8 reset scl", int'(scl_level), 1);
    check("R8 reset strobes", int'(period_stb | sda_drive_stb | sda_sample_stb), 0);
  endtask

  task automatic test_midchange();
    int i, p, l, d, s, nd, ns;
    program_word(0, 0, 0);
    wait_start();
    i = 0;
    do begin
      @(negedge clk); i++;
      if (i == 5) begin ctrl_word = 9'((1 << 3) | 1); edge_comp = 8'd0; end
    end while (!period_stb && i < 20000);
    check("R7 old period kept", i, 20);
    measure(p, l, d, s, nd, ns);
    check("R7 new period", p, 2 * 28);
    check("R7 new low time", l, 2 * 14);
  endtask

  task automatic test_disable();
    int bad = 0;
    program_word(2, 3, 9);
    wait_start();
    repeat (13) @(negedge clk);
    enable = 1'b0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (!scl_level || period_stb || sda_drive_stb || sda_sample_stb) bad++;
    end
    check("R8 disabled quiet", bad, 0);
    ctrl_word = 9'((0 << 3) | 0);
    edge_comp = 8'd4;
    @(negedge clk);
    enable = 1'b1;
    #1;
    check("R9 restart strobe", int'(period_stb), 1);
    check("R9 restart low", int'(scl_level), 0);
    @(negedge clk);
    begin
      int p, l, d, s, nd, ns;
      repeat (23) @(negedge clk);
      measure(p, l, d, s, nd, ns);
      check("R9 restart settings", p, 24);
    end
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    test_reset();
    run_timing("minimum", 0, 0, 0);
    run_timing("mixed", 3, 5, 17);
    run_timing("maximum", 7, 63, 255);
    run_timing("odd", 1, 2, 3);
    test_midchange();
    test_disable();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule